// File: doc/BRIEF.md
# Converter Serial Result Port

This block moves a finished conversion word out of a data converter over a single serial data line. It holds the most recent result and shifts it out most significant bit first. It can run in one of two modes, chosen by `masterMode`. In master mode it makes its own bit clock by dividing the system clock, and it drives a frame-sync output that marks the frame. In slave mode a host supplies the bit clock. That clock is brought into the system clock domain and its edges are detected there, so the host clock never clocks a flip-flop directly.

In slave mode the bits shifted in behind the result come from a chain input, so several converters can be linked onto one data line. If a host has started a read and not finished it when the next result arrives, the old word is dropped and a one-cycle error pulse is raised. The serial output is driven only while both active-low enables are low. Raising the select clears the read position, and the next read starts again from the top bit.

Top module: `sres_port`

## Requirements
- R1: The word is shifted out most significant bit first. In slave mode the shift register loads `resultWord` when `convDone` pulses. In master mode it loads when a frame starts.
- R2: In slave mode with `sclkInvert`=0, data moves only on rising `extSclk` edges and holds across the following falling edge. With `sclkInvert`=1 the edges swap roles. An update edge that comes before any sample edge in a read does not shift the data.
- R3: In slave mode, the `chainIn` level captured at sample edge k is driven on `sdo` in the bit period that ends at sample edge k+16.
- R4: In master mode, `sclkOut` idles low and toggles every `DIV_HALF` system clocks during a frame. Each frame gives exactly 16 rising edges, and `sdo` changes only after falling edges.
- R5: In master mode, `syncOut` is active from the cycle after the frame trigger until the clock stops, which is 32·`DIV_HALF` cycles. It is active high when `syncInvert`=0 and active low when it is 1. Outside a frame, and in slave mode, it sits at `syncInvert`.
- R6: In master mode with `readDuring`=0, a frame starts on `convDone` and sends the word presented with that strobe, and `convStart` is ignored. With `readDuring`=1, a frame starts on `convStart` and sends the word from the last `convDone`, and `convDone` alone does not start a frame.
- R7: In slave mode, if `convDone` arrives after 1 to 15 sample edges of the current read, `readError` is high for exactly the next cycle. The new word is then loaded and the read restarts at its top bit. After 0 or 16 or more sample edges, no pulse is raised.
- R8: `sdo` is 0 unless both `csN` and `rdN` are low.
- R9: In slave mode, while `csN` is high, `extSclk` edges are ignored and the bit position is cleared. The next read after `csN` falls starts from the top bit of the last word.
- R10: After reset, `sdo`, `sclkOut` and `readError` are 0, and `syncOut` equals `syncInvert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| resultWord | input | WIDTH | Latched conversion result |
| convDone | input | 1 | One-cycle strobe: new result available |
| convStart | input | 1 | One-cycle strobe: next conversion starting |
| masterMode | input | 1 | 1 = block drives the bit clock, 0 = host clock |
| sclkInvert | input | 1 | Slave clock edge select |
| syncInvert | input | 1 | Frame-sync polarity select |
| readDuring | input | 1 | Master read timing: 1 = during next conversion |
| chainIn | input | 1 | Daisy-chain serial data in |
| csN | input | 1 | Active-low chip select, gates the host clock |
| rdN | input | 1 | Active-low read enable |
| extSclk | input | 1 | Host bit clock (asynchronous) |
| sdo | output | 1 | Serial data out |
| sclkOut | output | 1 | Generated bit clock |
| syncOut | output | 1 | Frame sync |
| readError | output | 1 | Incomplete-read pulse |

## Verification
Slave reads are run with both clock-edge selections and with random words and chain patterns. Each bit is checked once after the update edge and again after the sample edge, which catches a design that shifts on the wrong edge. Reads longer than 16 bits check that the chain data arrives at exactly the right offset. Master frames are run with both sync polarities and both read timings, and the bench measures the clock period, the rise count and the sync width. In each master case a strobe that should be ignored is sent first. Directed cases cover a result arriving in the middle of a read, after a completed read and with the select high. They also cover dropping the select partway through a read and holding read enable high.

// File: rtl/sres_pkg.sv
package sres_pkg;
  typedef struct packed {
    logic loadNew;   // load shift register from incoming result word
    logic loadHold;  // load shift register from held word
    logic shift;     // advance one bit toward sdo
    logic capture;   // sample chain input
  } dpStrobe_t;
endpackage

// File: rtl/sres_edge_sync.sv
module sres_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut,
  output logic fallOut
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], asyncIn};
  end

  assign riseOut = pipe[STAGES-1] & ~pipe[STAGES];
  assign fallOut = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/sres_datapath.sv
module sres_datapath
  import sres_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [WIDTH-1:0] wordIn,
  input  logic             convDone,
  input  logic             chainIn,
  input  logic             outEnable,
  output logic             sdo
);
  logic [WIDTH-1:0] holdWord;
  logic [WIDTH-1:0] shiftReg;
  logic             chainBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      shiftReg <= '0;
      chainBit <= 1'b0;
    end else begin
      if (convDone) holdWord <= wordIn;
      if (strb.capture) chainBit <= chainIn;
      if (strb.loadNew)       shiftReg <= wordIn;
      else if (strb.loadHold) shiftReg <= holdWord;
      else if (strb.shift)    shiftReg <= {shiftReg[WIDTH-2:0], chainBit};
    end
  end

  assign sdo = outEnable ? shiftReg[WIDTH-1] : 1'b0;

  // R1: a load places the incoming word, MSB at the output end
  p_load_word_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNew |=> shiftReg == $past(wordIn))
    else $error("R1 load mismatch");

  // R1: a shift moves every bit one place toward the output
  p_shift_msb_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.loadNew && !strb.loadHold)
      |=> shiftReg[WIDTH-1:1] == $past(shiftReg[WIDTH-2:0]))
    else $error("R1 shift mismatch");
endmodule

// File: rtl/sres_ctrl.sv
module sres_ctrl
  import sres_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int DIV_HALF = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterMode,
  input  logic      sclkInvert,
  input  logic      syncInvert,
  input  logic      readDuring,
  input  logic      convDone,
  input  logic      convStart,
  input  logic      csN,
  input  logic      sclkRise,
  input  logic      sclkFall,
  output dpStrobe_t strb,
  output logic      sclkOut,
  output logic      syncOut,
  output logic      readError
);
  localparam int CNT_W  = $clog2(WIDTH + 1);
  localparam int HALF_W = $clog2(2 * WIDTH);
  localparam int DIV_W  = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(WIDTH);
  localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(2 * WIDTH - 1);
  localparam logic [DIV_W-1:0]  LAST_DIV = DIV_W'(DIV_HALF - 1);

  // ---------------- slave side ----------------
  logic [CNT_W-1:0] sampleCnt;
  logic             armed;
  logic             csPrev;
  logic             updEdge, smpEdge, slaveLoad, midRead, csRise, slaveShift;

  assign updEdge    = !masterMode && !csN && (sclkInvert ? sclkFall : sclkRise);
  assign smpEdge    = !masterMode && !csN && (sclkInvert ? sclkRise : sclkFall);
  assign slaveLoad  = !masterMode && convDone;
  assign midRead    = (sampleCnt != '0) && (sampleCnt < FULL_CNT);
  assign csRise     = csN && !csPrev;
  assign slaveShift = updEdge && armed && !slaveLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
      armed     <= 1'b0;
      csPrev    <= 1'b1;
      readError <= 1'b0;
    end else begin
      csPrev    <= csN;
      readError <= slaveLoad && midRead;
      if (slaveLoad || csN) begin
        sampleCnt <= '0;
        armed     <= 1'b0;
      end else if (smpEdge) begin
        armed <= 1'b1;
        if (sampleCnt < FULL_CNT) sampleCnt <= sampleCnt + 1'b1;
      end else if (updEdge && armed) begin
        armed <= 1'b0;
      end
    end
  end

  // ---------------- master side ----------------
  logic              frameActive;
  logic              sclkReg;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] halfCnt;
  logic [CNT_W-1:0]  riseCnt;
  logic              trigger, tick;

  assign trigger = masterMode && !frameActive && (readDuring ? convStart : convDone);
  assign tick    = frameActive && (divCnt == LAST_DIV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      sclkReg     <= 1'b0;
      divCnt      <= '0;
      halfCnt     <= '0;
      riseCnt     <= '0;
    end else if (trigger) begin
      frameActive <= 1'b1;
      sclkReg     <= 1'b0;
      divCnt      <= '0;
      halfCnt     <= '0;
      riseCnt     <= '0;
    end else if (frameActive) begin
      if (tick) begin
        divCnt  <= '0;
        sclkReg <= ~sclkReg;
        halfCnt <= halfCnt + 1'b1;
        if (!sclkReg) riseCnt <= riseCnt + 1'b1;
        if (halfCnt == LAST_HALF) frameActive <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // ---------------- strobes to datapath ----------------
  always_comb begin
    strb.loadNew  = slaveLoad || (trigger && !readDuring);
    strb.loadHold = (!masterMode && csRise) || (trigger && readDuring);
    strb.shift    = slaveShift || (tick && sclkReg);
    strb.capture  = smpEdge || (tick && !sclkReg);
  end

  assign sclkOut = sclkReg;
  assign syncOut = frameActive ^ syncInvert;

  // R7: the error flag is a single-cycle pulse
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    readError |=> !readError)
    else $error("R7 error longer than one cycle");

  // R7: the error only follows a result arriving in slave mode
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    readError |-> ($past(convDone) && !$past(masterMode)))
    else $error("R7 error without cause");

  // R9: deselect clears the bit position
  p_cs_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> sampleCnt == '0)
    else $error("R9 count not cleared");

  // R4: never more than WIDTH rising edges in one frame
  p_rise_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= FULL_CNT)
    else $error("R4 too many clock edges");

  // R4: generated clock idles low outside a frame
  p_idle_clock_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |-> !sclkReg)
    else $error("R4 clock not idle");

  // R4/R5: a frame closes only after the full edge count
  p_frame_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameActive) |-> riseCnt == FULL_CNT)
    else $error("R5 frame ended early");
endmodule

// File: rtl/sres_port.sv
module sres_port
  import sres_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] resultWord,
  input  logic             convDone,
  input  logic             convStart,
  input  logic             masterMode,
  input  logic             sclkInvert,
  input  logic             syncInvert,
  input  logic             readDuring,
  input  logic             chainIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             extSclk,
  output logic             sdo,
  output logic             sclkOut,
  output logic             syncOut,
  output logic             readError
);
  dpStrobe_t strb;
  logic      sclkRise, sclkFall;
  logic      outEnable;

  assign outEnable = !csN && !rdN;

  sres_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extSclk),
    .riseOut (sclkRise),
    .fallOut (sclkFall)
  );

  sres_ctrl #(.WIDTH(WIDTH), .DIV_HALF(DIV_HALF)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterMode (masterMode),
    .sclkInvert (sclkInvert),
    .syncInvert (syncInvert),
    .readDuring (readDuring),
    .convDone   (convDone),
    .convStart  (convStart),
    .csN        (csN),
    .sclkRise   (sclkRise),
    .sclkFall   (sclkFall),
    .strb       (strb),
    .sclkOut    (sclkOut),
    .syncOut    (syncOut),
    .readError  (readError)
  );

  sres_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wordIn    (resultWord),
    .convDone  (convDone),
    .chainIn   (chainIn),
    .outEnable (outEnable),
    .sdo       (sdo)
  );

  // R8: output stays quiet while not enabled
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sdo)
    else $error("R8 output active while deselected");
endmodule

// File: tb/sres_port_tb.sv
module sres_port_tb;
  localparam int WIDTH = 16;
  localparam int DIV_HALF = 2;

  logic clk = 1'b0;
  logic rstN;
  logic [WIDTH-1:0] resultWord;
  logic convDone, convStart, masterMode, sclkInvert, syncInvert, readDuring;
  logic chainIn, csN, rdN, extSclk;
  logic sdo, sclkOut, syncOut, readError;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sres_port #(.WIDTH(WIDTH), .DIV_HALF(DIV_HALF), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .resultWord(resultWord), .convDone(convDone),
    .convStart(convStart), .masterMode(masterMode), .sclkInvert(sclkInvert),
    .syncInvert(syncInvert), .readDuring(readDuring), .chainIn(chainIn),
    .csN(csN), .rdN(rdN), .extSclk(extSclk), .sdo(sdo), .sclkOut(sclkOut),
    .syncOut(syncOut), .readError(readError)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic expSlaveBit(input int k, input logic [15:0] word,
                                       input logic [63:0] chain);
    return (k <= 16) ? word[16-k] : chain[k-16];
  endfunction

  task automatic pulseDone(input logic [15:0] word);
    resultWord = word;
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic pulseStart();
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
  endtask

  task automatic slaveSetup(input logic inv);
    csN = 1'b1;
    masterMode = 1'b0;
    sclkInvert = inv;
    extSclk = inv;
    repeat (6) @(negedge clk);
  endtask

  // each bit checked after the update edge and again after the sample edge
  task automatic slaveClock(input logic inv, input int iters, input logic [15:0] word,
                            input logic [63:0] chain, input string req);
    for (int k = 1; k <= iters; k++) begin
      logic expBit;
      extSclk = ~inv;
      repeat (4) @(negedge clk);
      expBit = expSlaveBit(k, word, chain);
      chk(req, sdo, expBit);
      chainIn = chain[k];
      extSclk = inv;
      repeat (4) @(negedge clk);
      chk(req, sdo, expBit);
    end
  endtask

  task automatic slaveRead(input logic inv, input int iters, input logic [15:0] word,
                           input logic [63:0] chain, input string req);
    slaveSetup(inv);
    pulseDone(word);
    chk("R7 no error when idle", readError, 0);
    csN = 1'b0;
    rdN = 1'b0;
    @(negedge clk);
    slaveClock(inv, iters, word, chain, req);
    csN = 1'b1;
    @(negedge clk);
  endtask

  task automatic masterFrame(input logic [15:0] word, input logic sInv, input logic rdur);
    int rises = 0;
    int lastRise = 0;
    int endCyc = -1;
    logic prevS = 1'b0;
    csN = 1'b1;
    masterMode = 1'b1;
    syncInvert = sInv;
    readDuring = rdur;
    repeat (2) @(negedge clk);
    csN = 1'b0;
    rdN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 sync idle level", syncOut, sInv);
    if (rdur) begin
      pulseDone(word);
      repeat (5) @(negedge clk);
      chk("R6 convDone alone starts no frame", syncOut, sInv);
      pulseStart();
    end else begin
      pulseStart();
      repeat (5) @(negedge clk);
      chk("R6 convStart ignored", syncOut, sInv);
      pulseDone(word);
    end
    chk("R5 sync active at frame start", syncOut, !sInv);
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (sclkOut && !prevS) begin
        rises++;
        if (rises <= 16) chk("R1 master bit order", sdo, word[16-rises]);
        if (rises > 1) chk("R4 clock period", cyc - lastRise, 2 * DIV_HALF);
        lastRise = cyc;
      end
      if (syncOut == sInv) begin
        endCyc = cyc;
        break;
      end
      prevS = sclkOut;
      @(negedge clk);
    end
    chk("R4 rising edges per frame", rises, 16);
    chk("R4 clock idle after frame", sclkOut, 0);
    chk("R5 sync width", endCyc, 2 * WIDTH * DIV_HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] chain;
    void'($urandom(32'd4242));
    rstN = 1'b0;
    resultWord = '0; convDone = 1'b0; convStart = 1'b0; masterMode = 1'b0;
    sclkInvert = 1'b0; syncInvert = 1'b0; readDuring = 1'b0; chainIn = 1'b0;
    csN = 1'b1; rdN = 1'b1; extSclk = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 sdo reset", sdo, 0);
    chk("R10 sclkOut reset", sclkOut, 0);
    chk("R10 syncOut reset", syncOut, 0);
    chk("R10 readError reset", readError, 0);

    // directed slave reads, both edge choices, with chain tail
    chain = 64'h0000_0000_00A5_3C96;
    slaveRead(1'b0, 24, 16'hB35A, chain, "R2 R3 slave rising update");
    slaveRead(1'b1, 24, 16'h4C1F, ~chain, "R2 R3 slave falling update");
    chk("R5 sync held in slave mode", syncOut, syncInvert);

    // R8: read enable high keeps the line quiet
    slaveSetup(1'b0);
    pulseDone(16'h8001);
    csN = 1'b0; rdN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 quiet with rdN high", sdo, 0);
    rdN = 1'b0;
    @(negedge clk);
    chk("R8 drives MSB when enabled", sdo, 1);
    csN = 1'b1;
    @(negedge clk);

    // R7: result arriving mid-read, then after a complete read
    slaveSetup(1'b0);
    pulseDone(16'hF00D);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    slaveClock(1'b0, 5, 16'hF00D, 64'h0, "R1 partial read");
    pulseDone(16'h1234);
    chk("R7 error pulse on mid-read result", readError, 1);
    @(negedge clk);
    chk("R7 error pulse one cycle", readError, 0);
    slaveClock(1'b0, 16, 16'h1234, 64'h0, "R7 new word from MSB");
    pulseDone(16'hC3A5);
    chk("R7 no error after full read", readError, 0);
    @(negedge clk);
    chk("R7 no error after full read, next cycle", readError, 0);

    // R9: deselect mid-read, clock while deselected, restart from MSB
    slaveClock(1'b0, 6, 16'hC3A5, 64'h0, "R9 partial before deselect");
    csN = 1'b1;
    @(negedge clk);
    chk("R8 quiet while deselected", sdo, 0);
    for (int t = 0; t < 4; t++) begin
      extSclk = ~extSclk;
      repeat (4) @(negedge clk);
    end
    csN = 1'b0;
    @(negedge clk);
    slaveClock(1'b0, 16, 16'hC3A5, 64'h0, "R9 restart from MSB");
    csN = 1'b1;
    pulseDone(16'h0F0F);
    chk("R7 no error while deselected", readError, 0);

    // directed master frames, all polarity / timing combinations
    masterFrame(16'hA5C3, 1'b0, 1'b0);
    masterFrame(16'h3C5A, 1'b1, 1'b0);
    masterFrame(16'h9E17, 1'b0, 1'b1);
    masterFrame(16'h61E8, 1'b1, 1'b1);

    // random mix
    for (int n = 0; n < 6; n++) begin
      logic [15:0] w = 16'($urandom);
      logic inv = 1'($urandom);
      chain = {$urandom, $urandom};
      slaveRead(inv, 16 + int'($urandom % 9), w, chain, "R1 R2 R3 random slave");
    end
    for (int n = 0; n < 6; n++) begin
      masterFrame(16'($urandom), 1'($urandom), 1'($urandom));
    end

    csN = 1'b1;
    masterMode = 1'b0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule